// File: doc/BRIEF.md
# FPU Exception Interrupt Register Block

This block sits next to a processor core's floating-point unit and turns its six exception indications into one interrupt request. Each exception line is captured into a sticky status bit. Software chooses which captured exceptions may raise the interrupt through an enable mask. The mask is never written directly: one register sets enable bits and another clears them, so independent software tasks cannot undo each other's changes.

A small 32-bit register bus gives access to the block. It carries a byte address, a write strobe, write data and combinational read data. A read-only information word reports which core the block belongs to and whether an FPU is fitted. Both values come from static strap inputs. With no FPU fitted, every FPU-related register reads zero, ignores writes and never raises the interrupt.

Top module: `fpux_irq_regs`

## Requirements
- R1: After reset, raw status and mask read zero and `irq_o` is low.
- R2: Offset 0x00 is read-only. Bit 0 returns `core_id_i` (0 = communication core, 1 = application core), bit 1 returns `fpu_present_i`, and bits 31..2 read zero.
- R3: Raw status at offset 0x04 sets bit n at the clock edge where `exc_i[n]` is high. Bit order from bit 0 is inexact, underflow, overflow, divide-by-zero, invalid operation, input denormal. Bits 31..6 of every FPU register read zero.
- R4: Writing 1 to a raw status bit clears it. Writing 0 leaves it unchanged.
- R5: If an exception line is high in the same cycle that software clears its bit, the bit stays set.
- R6: Writing 1 to a bit at offset 0x0C enables that source, and writing 0 has no effect. Reads of 0x0C and 0x10 both return the current mask.
- R7: Writing 1 to a bit at offset 0x10 disables that source, and writing 0 has no effect.
- R8: Offset 0x08 reads raw status AND mask. Writes to it change nothing.
- R9: `irq_o` is active high. It equals the OR of the masked status bits, delayed by one register stage.
- R10: With `fpu_present_i` low, offsets 0x04 to 0x10 read zero, writes and exception lines change nothing, and `irq_o` stays low.
- R11: Reads from any other offset return zero, and writes to any other offset change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| core_id_i | input | 1 | Static strap: core identity |
| fpu_present_i | input | 1 | Static strap: FPU fitted |
| addr_i | input | 8 | Byte address of the register access |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for `addr_i`, combinational |
| exc_i | input | 6 | Exception lines from the FPU |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume the two straps hold still between resets. The bench only changes them while reset is asserted, and it brings up a separate phase for the no-FPU case. The assertions also assume that a write strobe lasts one cycle and that the address stays stable while the strobe is high. The bench drives every bus and exception input on the falling edge, so each strobe covers exactly one rising edge. The sweep goes through all 64 exception patterns, each paired with a computed mask and a computed clear pattern.

// File: rtl/fpux_pkg.sv
package fpux_pkg;
  localparam int EXC_N  = 6;
  localparam int DATA_W = 32;

  localparam int OFS_INFO = 'h00;
  localparam int OFS_RAW  = 'h04;
  localparam int OFS_MSKD = 'h08;
  localparam int OFS_MSET = 'h0C;
  localparam int OFS_MCLR = 'h10;

  typedef enum logic [2:0] {
    SEL_INFO,
    SEL_RAW,
    SEL_MSKD,
    SEL_MSET,
    SEL_MCLR,
    SEL_NONE
  } fpux_sel_e;
endpackage

// File: rtl/fpux_decode.sv
module fpux_decode
  import fpux_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output fpux_sel_e         sel_o
);
  always_comb begin
    if (addr_i == ADDR_W'(OFS_INFO))      sel_o = SEL_INFO;
    else if (addr_i == ADDR_W'(OFS_RAW))  sel_o = SEL_RAW;
    else if (addr_i == ADDR_W'(OFS_MSKD)) sel_o = SEL_MSKD;
    else if (addr_i == ADDR_W'(OFS_MSET)) sel_o = SEL_MSET;
    else if (addr_i == ADDR_W'(OFS_MCLR)) sel_o = SEL_MCLR;
    else                                  sel_o = SEL_NONE;
  end
endmodule

// File: rtl/fpux_status.sv
module fpux_status #(
  parameter int N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [N-1:0] exc_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] raw_o
);
  logic [N-1:0] raw_q;
  logic [N-1:0] raw_d;

  for (genvar i = 0; i < N; i++) begin : g_bit
    // hardware set takes priority over a software clear
    always_comb begin
      if (en_i) raw_d[i] = exc_i[i] | (raw_q[i] & ~clr_i[i]);
      else      raw_d[i] = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) raw_q[i] <= 1'b0;
      else         raw_q[i] <= raw_d[i];
    end

    // R5
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i && exc_i[i] |=> raw_q[i]);
    // R4
    clear_works_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[i] && !exc_i[i] |=> !raw_q[i]);
    // R4
    sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i && raw_q[i] && !clr_i[i] |=> raw_q[i]);
  end

  assign raw_o = raw_q;
endmodule

// File: rtl/fpux_mask.sv
module fpux_mask #(
  parameter int N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] mask_o
);
  logic [N-1:0] mask_q;
  logic [N-1:0] mask_d;
  logic         upd;

  assign upd = ~en_i | (|set_i) | (|clr_i);

  always_comb begin
    if (en_i) mask_d = (mask_q | set_i) & ~clr_i;
    else      mask_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  mask_q <= '0;
    else if (upd) mask_q <= mask_d;
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R6
    mask_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i && set_i[i] && !clr_i[i] |=> mask_q[i]);
    // R7
    mask_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[i] |=> !mask_q[i]);
    // R6
    mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i && !set_i[i] && !clr_i[i] |=> $stable(mask_q[i]));
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/fpux_irq_gen.sv
module fpux_irq_gen #(
  parameter int N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] raw_i,
  input  logic [N-1:0] mask_i,
  output logic         irq_o
);
  logic irq_q;
  logic irq_d;

  always_comb irq_d = |(raw_i & mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_d;
  end

  // R9
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(raw_i & mask_i)) |=> irq_q);
  // R9
  irq_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(raw_i & mask_i)) |=> !irq_q);

  assign irq_o = irq_q;
endmodule

// File: rtl/fpux_irq_regs.sv
module fpux_irq_regs
  import fpux_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              core_id_i,
  input  logic              fpu_present_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [EXC_N-1:0]  exc_i,
  output logic              irq_o
);
  localparam int PAD_W = DATA_W - EXC_N;

  fpux_sel_e        sel;
  logic [EXC_N-1:0] raw;
  logic [EXC_N-1:0] mask;
  logic [EXC_N-1:0] raw_clr;
  logic [EXC_N-1:0] msk_set;
  logic [EXC_N-1:0] msk_clr;
  logic [EXC_N-1:0] wr_bits;

  fpux_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  assign wr_bits = wr_data_i[EXC_N-1:0];

  always_comb begin
    raw_clr = '0;
    msk_set = '0;
    msk_clr = '0;
    if (wr_en_i && fpu_present_i) begin
      case (sel)
        SEL_RAW:  raw_clr = wr_bits;
        SEL_MSET: msk_set = wr_bits;
        SEL_MCLR: msk_clr = wr_bits;
        default:  ;
      endcase
    end
  end

  fpux_status #(.N(EXC_N)) u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (fpu_present_i),
    .exc_i  (exc_i),
    .clr_i  (raw_clr),
    .raw_o  (raw)
  );

  fpux_mask #(.N(EXC_N)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (fpu_present_i),
    .set_i  (msk_set),
    .clr_i  (msk_clr),
    .mask_o (mask)
  );

  fpux_irq_gen #(.N(EXC_N)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (raw),
    .mask_i (mask),
    .irq_o  (irq_o)
  );

  always_comb begin
    rd_data_o = '0;
    case (sel)
      SEL_INFO: rd_data_o = {{(DATA_W-2){1'b0}}, fpu_present_i, core_id_i};
      SEL_RAW:  rd_data_o = {{PAD_W{1'b0}}, raw};
      SEL_MSKD: rd_data_o = {{PAD_W{1'b0}}, raw & mask};
      SEL_MSET,
      SEL_MCLR: rd_data_o = {{PAD_W{1'b0}}, mask};
      default:  rd_data_o = '0;
    endcase
  end

  // R10
  absent_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fpu_present_i |=> (raw == '0) && (mask == '0) && !irq_o);
  // R11
  unmapped_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (sel == SEL_NONE || sel == SEL_MSKD || sel == SEL_INFO) && (exc_i == '0)
    |=> $stable(raw) && $stable(mask));
  // R3
  upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[DATA_W-1:EXC_N] == '0);
endmodule

// File: tb/fpux_irq_regs_tb.sv
module fpux_irq_regs_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        core_id;
  logic        present;
  logic [7:0]  addr;
  logic        wr_en;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [5:0]  exc;
  logic        irq;

  int checks;
  int fails;

  fpux_irq_regs u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .core_id_i     (core_id),
    .fpu_present_i (present),
    .addr_i        (addr),
    .wr_en_i       (wr_en),
    .wr_data_i     (wdata),
    .rd_data_o     (rdata),
    .exc_i         (exc),
    .irq_o         (irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [5:0] p);
    @(negedge clk);
    exc = p;
    @(negedge clk);
    exc = '0;
  endtask

  task automatic do_reset(input logic cid, input logic pres);
    @(negedge clk);
    rst_n = 1'b0; core_id = cid; present = pres;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    checks = 0; fails = 0;
    rst_n = 1'b0; core_id = 1'b1; present = 1'b1;
    addr = '0; wr_en = 1'b0; wdata = '0; exc = '0;
    do_reset(1'b1, 1'b1);

    // R1 reset state
    rd(8'h04, v); chk("R1 raw", v, 0);
    rd(8'h0C, v); chk("R1 mask", v, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    // R2 info word
    rd(8'h00, v); chk("R2 info", v, 32'h3);

    for (int p = 0; p < 64; p++) begin
      logic [5:0] m, c, pv;
      pv = 6'(p);
      m  = 6'((p * 37 + 11) & 63);
      c  = 6'((p * 13 + 5) & 63);
      pulse(pv);
      rd(8'h04, v); chk("R3 raw capture", v, {26'd0, pv});
      wr(8'h0C, {26'd0, m});
      rd(8'h0C, v); chk("R6 mask via set", v, {26'd0, m});
      rd(8'h10, v); chk("R6 mask via clr", v, {26'd0, m});
      rd(8'h08, v); chk("R8 masked", v, {26'd0, pv & m});
      @(negedge clk);
      chk("R9 irq", {31'd0, irq}, {31'd0, (pv & m) != 0});
      wr(8'h04, {26'd0, c});
      rd(8'h04, v); chk("R4 partial clear", v, {26'd0, pv & ~c});
      wr(8'h10, {26'd0, c});
      rd(8'h0C, v); chk("R7 mask clear", v, {26'd0, m & ~c});
      wr(8'h04, 32'h3F);
      wr(8'h10, 32'h3F);
    end

    // R5 set beats simultaneous clear
    @(negedge clk);
    exc = 6'h09; addr = 8'h04; wdata = 32'h3F; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    rd(8'h04, v); chk("R5 reassert", v, 32'h09);
    exc = '0;
    wr(8'h04, 32'h3F);
    rd(8'h04, v); chk("R5 cleared after release", v, 0);

    // R3 upper bits zero
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, v); chk("R3 upper bits", v, 32'h3F);
    pulse(6'h2A);
    // R8 write to masked register ignored
    wr(8'h08, 32'h3F);
    rd(8'h04, v); chk("R8 raw untouched", v, 32'h2A);
    rd(8'h0C, v); chk("R8 mask untouched", v, 32'h3F);
    // R11 unmapped offsets
    wr(8'h14, 32'h3F);
    wr(8'h80, 32'hFFFF_FFFF);
    rd(8'h04, v); chk("R11 raw untouched", v, 32'h2A);
    rd(8'h0C, v); chk("R11 mask untouched", v, 32'h3F);
    rd(8'h14, v); chk("R11 read zero", v, 0);
    rd(8'h80, v); chk("R11 read zero high", v, 0);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, v); chk("R2 info read-only", v, 32'h3);

    // R10 FPU absent
    do_reset(1'b0, 1'b0);
    rd(8'h00, v); chk("R2 info absent", v, 0);
    @(negedge clk);
    exc = 6'h3F;
    wr(8'h0C, 32'h3F);
    @(negedge clk);
    rd(8'h04, v); chk("R10 raw zero", v, 0);
    rd(8'h08, v); chk("R10 masked zero", v, 0);
    rd(8'h0C, v); chk("R10 mask set zero", v, 0);
    rd(8'h10, v); chk("R10 mask clr zero", v, 0);
    chk("R10 irq low", {31'd0, irq}, 0);
    exc = '0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule